// File: doc/BRIEF.md
# Instruction Prefetch Address Breakpoint Unit

This unit watches the instruction prefetch stream of a processor core and raises a break interrupt request when a fetch lands on one programmed 24-bit address. Software programs the target address and an enable bit through an 8-bit register port. When an opcode fetch hits the address while the enable is on, a sticky match flag is set. The request output stays high while the flag and the enable are both set.

The flag cannot be cleared by a register write. It falls only when the core acknowledges the break exception. Data accesses never reach the comparator, because only cycles that carry the prefetch strobe are compared. A mode input picks between a 16-bit address space, where the top address byte is not compared, and the full 24-bit space.

Top module: `pfbrk_top`

## Requirements
- R1: After reset every register reads 0x00 and `breakReq` is 0.
- R2: Register select 0 is the control/status byte. Bit 0 is the enable and can be read and written. Bit 7 is the match flag, reads as it stands, and ignores writes. Bits 6..1 always read 0 and ignore writes.
- R3: Register selects 1, 2 and 3 hold break address bits 23..16, 15..8 and 7..0 respectively. Each reads back what was last written to it.
- R4: With `advMode`=1, a prefetch hits only when all 24 address bits equal the break address.
- R5: With `advMode`=0, a prefetch hits when bits 15..0 are equal, whatever bits 23..16 hold.
- R6: The flag is set by a hit sampled at a clock edge with `fetchValid`=1 and the enable at 1. It reads as 1 from the following cycle. With the enable at 0, no fetch sets it.
- R7: A cycle with `fetchValid`=0 never sets the flag, whatever `fetchAddr` holds.
- R8: Once set, the flag stays 1 through any register write, including a write that clears the enable. It clears one cycle after an `excAck` pulse.
- R9: A hit and `excAck` in the same cycle leave the flag at 1.
- R10: `breakReq` is 1 exactly when both the flag and the enable are 1.
- R11: A write to an address byte is used for comparisons from the next cycle on. A fetch in the same cycle compares against the old value. A write never sets the flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control, 1 high, 2 middle, 3 low address byte |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (combinational) |
| fetchValid | input | 1 | High in an instruction prefetch cycle |
| fetchAddr | input | 24 | Prefetch address |
| advMode | input | 1 | 1: compare 24 bits, 0: compare 16 bits |
| excAck | input | 1 | Break exception acknowledge pulse |
| breakReq | output | 1 | Break interrupt request |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that `excAck` is the only agent that is allowed to clear the flag. The checks on flag set and clear read the internal hit and flag nets, so they do not depend on how the core sequences exceptions. The bench changes every input on the falling edge only, so the inputs are steady at the rising edge. It issues acknowledges at arbitrary points, including cycles with no pending request and cycles that collide with a hit.

// File: rtl/pfbrk_pkg.sv
package pfbrk_pkg;
  localparam int PF_ADDR_W  = 24;
  localparam int PF_DATA_W  = 8;
  localparam int PF_SHORT_W = 16;
  localparam int PF_BYTES   = PF_ADDR_W / PF_DATA_W;
  localparam int PF_SEL_W   = $clog2(PF_BYTES + 1);
  localparam int PF_FLAG_BIT = PF_DATA_W - 1;

  typedef struct packed {
    logic [PF_BYTES-1:0] byteWr;
    logic                fetchArm;
  } pfStrobe_t;
endpackage

// File: rtl/pfbrk_ctrl.sv
module pfbrk_ctrl
  import pfbrk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PF_SEL_W-1:0]  regSel,
  input  logic                 regWr,
  input  logic [PF_DATA_W-1:0] regWdata,
  input  logic                 fetchValid,
  input  logic                 excAck,
  input  logic                 addrHit,
  output pfStrobe_t            strobe,
  output logic                 enable,
  output logic                 matchFlag,
  output logic [PF_DATA_W-1:0] statusByte,
  output logic                 breakReq
);
  logic ctrlWr;

  assign ctrlWr = regWr && (regSel == '0);

  for (genvar k = 0; k < PF_BYTES; k++) begin : g_sel
    assign strobe.byteWr[k] = regWr && (regSel == PF_SEL_W'(k + 1));
  end

  assign strobe.fetchArm = fetchValid && enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
    end else if (ctrlWr) begin
      enable <= regWdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
    end else if (addrHit) begin
      matchFlag <= 1'b1;
    end else if (excAck) begin
      matchFlag <= 1'b0;
    end
  end

  always_comb begin
    statusByte              = '0;
    statusByte[PF_FLAG_BIT] = matchFlag;
    statusByte[0]           = enable;
  end

  assign breakReq = matchFlag && enable;
endmodule

// File: rtl/pfbrk_dpath.sv
module pfbrk_dpath
  import pfbrk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pfStrobe_t            strobe,
  input  logic [PF_SEL_W-1:0]  regSel,
  input  logic [PF_DATA_W-1:0] regWdata,
  input  logic [PF_ADDR_W-1:0] fetchAddr,
  input  logic                 advMode,
  output logic                 addrHit,
  output logic [PF_DATA_W-1:0] addrRdata
);
  localparam logic [PF_ADDR_W-1:0] FULL_MASK  = '1;
  localparam logic [PF_ADDR_W-1:0] SHORT_MASK =
    {{(PF_ADDR_W - PF_SHORT_W){1'b0}}, {PF_SHORT_W{1'b1}}};

  logic [PF_DATA_W-1:0] bytes [PF_BYTES];
  logic [PF_ADDR_W-1:0] breakAddr;
  logic [PF_ADDR_W-1:0] cmpMask;

  for (genvar k = 0; k < PF_BYTES; k++) begin : g_byte
    localparam int HI = PF_ADDR_W - 1 - k * PF_DATA_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bytes[k] <= '0;
      end else if (strobe.byteWr[k]) begin
        bytes[k] <= regWdata;
      end
    end
    assign breakAddr[HI -: PF_DATA_W] = bytes[k];
  end

  assign cmpMask = advMode ? FULL_MASK : SHORT_MASK;
  assign addrHit = strobe.fetchArm && (((fetchAddr ^ breakAddr) & cmpMask) == '0);

  always_comb begin
    addrRdata = '0;
    for (int k = 0; k < PF_BYTES; k++) begin
      if (regSel == PF_SEL_W'(k + 1)) addrRdata = bytes[k];
    end
  end
endmodule

// File: rtl/pfbrk_top.sv
module pfbrk_top
  import pfbrk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PF_SEL_W-1:0]  regSel,
  input  logic                 regWr,
  input  logic [PF_DATA_W-1:0] regWdata,
  output logic [PF_DATA_W-1:0] regRdata,
  input  logic                 fetchValid,
  input  logic [PF_ADDR_W-1:0] fetchAddr,
  input  logic                 advMode,
  input  logic                 excAck,
  output logic                 breakReq
);
  pfStrobe_t            strobe;
  logic                 enable;
  logic                 matchFlag;
  logic                 addrHit;
  logic [PF_DATA_W-1:0] statusByte;
  logic [PF_DATA_W-1:0] addrRdata;

  pfbrk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .fetchValid(fetchValid), .excAck(excAck), .addrHit(addrHit), .strobe(strobe),
    .enable(enable), .matchFlag(matchFlag), .statusByte(statusByte), .breakReq(breakReq)
  );

  pfbrk_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel), .regWdata(regWdata),
    .fetchAddr(fetchAddr), .advMode(advMode), .addrHit(addrHit), .addrRdata(addrRdata)
  );

  assign regRdata = (regSel == '0) ? statusByte : addrRdata;
endmodule

// File: rtl/pfbrk_checker.sv
module pfbrk_checker
  import pfbrk_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [PF_SEL_W-1:0]  regSel,
  input logic [PF_DATA_W-1:0] regRdata,
  input logic                 fetchValid,
  input logic                 excAck,
  input logic                 enable,
  input logic                 matchFlag,
  input logic                 addrHit,
  input logic                 breakReq
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == '0) |-> (regRdata[PF_DATA_W-2:1] == '0));

  p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrHit |=> matchFlag);

  p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !matchFlag) |=> !matchFlag);

  p_no_fetch_no_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !matchFlag) |=> !matchFlag);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !excAck) |=> matchFlag);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (excAck && !fetchValid) |=> !matchFlag);

  p_collision_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excAck && addrHit) |=> matchFlag);

  p_req_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> (matchFlag && enable));
endmodule

bind pfbrk_top pfbrk_checker i_checker (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regRdata(regRdata),
  .fetchValid(fetchValid), .excAck(excAck), .enable(enable),
  .matchFlag(matchFlag), .addrHit(addrHit), .breakReq(breakReq)
);

// File: tb/test_pfbrk_top.sv
module test_pfbrk_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        fetchValid = 1'b0;
  logic [23:0] fetchAddr = '0;
  logic        advMode = 1'b0;
  logic        excAck = 1'b0;
  logic        breakReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  bit       mEn = 0;
  bit       mFlag = 0;
  bit [7:0] mByte [3];

  always #2 clk = ~clk;

  pfbrk_top i_pfbrk_top (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .advMode(advMode), .excAck(excAck), .breakReq(breakReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] modelRead(input bit [1:0] s);
    if (s == 0) return {mFlag, 6'b0, mEn};
    return mByte[s - 1];
  endfunction

  // one clock: model update at posedge, compare at negedge
  task automatic cyc();
    bit [23:0] a;
    bit hit;
    @(posedge clk);
    a = {mByte[0], mByte[1], mByte[2]};
    if (advMode) hit = fetchValid && mEn && (fetchAddr == a);
    else         hit = fetchValid && mEn && (fetchAddr[15:0] == a[15:0]);
    if (hit) mFlag = 1;
    else if (excAck) mFlag = 0;
    if (regWr) begin
      if (regSel == 0) mEn = regWdata[0];
      else mByte[regSel - 1] = regWdata;
    end
    @(negedge clk);
    regWr = 0; fetchValid = 0; excAck = 0;
    chk("R10 model breakReq", int'(breakReq), int'(mFlag && mEn));
    chk("R2/R3 model readback", int'(regRdata), int'(modelRead(regSel)));
  endtask

  task automatic wr(input bit [1:0] s, input bit [7:0] d);
    regSel = s; regWr = 1; regWdata = d;
    cyc();
  endtask

  task automatic fetch(input bit [23:0] a, input bit adv);
    fetchValid = 1; fetchAddr = a; advMode = adv;
    cyc();
  endtask

  task automatic rd(input bit [1:0] s, input string tag, input int exp);
    regSel = s;
    #1;
    chk(tag, int'(regRdata), exp);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mByte[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) rd(2'(s), "R1 reset read", 0);
    chk("R1 reset breakReq", int'(breakReq), 0);

    // R3 address bytes
    wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h56);
    rd(1, "R3 high byte", 8'h12);
    rd(2, "R3 mid byte", 8'h34);
    rd(3, "R3 low byte", 8'h56);

    // R2 control write ignores reserved and flag bits
    wr(0, 8'hFF);
    rd(0, "R2 control readback", 8'h01);
    chk("R2 no request yet", int'(breakReq), 0);

    // R4 full match in advanced mode, R6 visible next cycle
    fetch(24'h123456, 1);
    chk("R6 flag after hit", int'(breakReq), 1);
    rd(0, "R6 status after hit", 8'h81);

    // R10 / R8 disabling keeps flag, drops request
    wr(0, 8'h00);
    chk("R10 req off with enable 0", int'(breakReq), 0);
    rd(0, "R8 flag kept on disable", 8'h80);
    wr(0, 8'h01);
    chk("R8 req back on re-enable", int'(breakReq), 1);
    wr(0, 8'h01);
    rd(0, "R8 write does not clear flag", 8'h81);

    // R8 ack clears
    excAck = 1; cyc();
    rd(0, "R8 cleared by ack", 8'h01);

    // R4 high byte mismatch in advanced mode
    fetch(24'hFF3456, 1);
    chk("R4 high byte mismatch", int'(breakReq), 0);
    // R5 normal mode ignores high byte
    fetch(24'hFF3456, 0);
    chk("R5 normal mode hit", int'(breakReq), 1);
    excAck = 1; cyc();
    fetch(24'h123457, 0);
    chk("R5 low bits mismatch", int'(breakReq), 0);

    // R7 matching address without prefetch strobe
    fetchAddr = 24'h123456; advMode = 1; cyc();
    chk("R7 non-prefetch cycle", int'(breakReq), 0);

    // R9 hit and ack together
    excAck = 1; fetch(24'h123456, 1);
    chk("R9 set wins over ack", int'(breakReq), 1);
    excAck = 1; cyc();
    chk("R8 ack after collision", int'(breakReq), 0);

    // R11 write and fetch in same cycle use old value
    regSel = 3; regWr = 1; regWdata = 8'h57;
    fetchValid = 1; fetchAddr = 24'h123457; advMode = 1;
    cyc();
    chk("R11 same-cycle write not used", int'(breakReq), 0);
    fetch(24'h123457, 1);
    chk("R11 new value used next cycle", int'(breakReq), 1);
    excAck = 1; cyc();
    wr(2, 8'h00);
    chk("R11 write alone no set", int'(breakReq), 0);

    // R6 disabled enable blocks set
    wr(0, 8'h00);
    fetch(24'h120057, 1);
    rd(0, "R6 no set while disabled", 8'h00);

    // random traffic compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      regSel = 2'($urandom_range(0, 3));
      regWr = ($urandom_range(0, 7) == 0);
      regWdata = 8'($urandom);
      fetchValid = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 1) == 1)
        fetchAddr = {($urandom_range(0, 1) == 1) ? mByte[0] : 8'($urandom), mByte[1], mByte[2]};
      else
        fetchAddr = 24'($urandom);
      advMode = $urandom_range(0, 1) == 1;
      excAck = ($urandom_range(0, 5) == 0);
      cyc();
    end

    done = 1;
    finishRun();
  end
endmodule